// File: doc/BRIEF.md
# PLL Relock Sequencer

This block reprograms a clock synthesiser through two 32-bit control words and walks it through a safe relock. A request carries the true feedback, reference and output divider values. The block checks that each value is in range and stores each one as its value minus one. It then drives the control words in a fixed order. The order is: enter bypass and reset with the new reference divider, load the feedback and output dividers, hold reset, release reset while still bypassed, wait for lock, and finally leave bypass.

The reset hold is measured with an internal microsecond tick, built from a parameterised count of system clocks per microsecond. The lock wait counts pulses on `ref_tick`, one pulse per cycle of the synthesiser's input clock. The wait lasts `LOCK_PERIODS` times the reference divider, so it always spans the required number of divided-reference periods. While bypass is set, the synthesiser output equals its input. Otherwise the output is f_in × F / (2 × R × OD).

A `start`/`busy`/`done` handshake frames each request. `done` pulses for one cycle on the edge that clears bypass.

Top module: `pllseq_top`

## Requirements
- R1: After a synchronous reset, `ctl0` is 0 and `ctl1` is 0x1200_0000 (reset bit 28 and bypass bit 25 set). `busy` and `done` are 0.
- R2: A valid `start` seen while idle raises `busy` on the next edge. On the edge after that, `ctl1` becomes 0x1600_0000 | (R−1): reset (28), saturation-enable (26) and bypass (25) set, with the reference divider minus one in bits 5:0.
- R3: One edge after `ctl1` is loaded, `ctl0` takes (F−1) in bits 16:4, (OD−1) in bits 2:0 and ((F−1) >> 1) in bits 31:20. All other bits are 0.
- R4: Reset stays set for exactly HOLD_US × CYCLES_PER_US clocks after `ctl0` is loaded. It is then cleared while bypass stays set, giving `ctl1` = 0x0600_0000 | (R−1).
- R5: After reset is released, bypass is cleared on the edge that samples the LOCK_PERIODS × R-th `ref_tick` pulse. This gives `ctl1` = 0x0400_0000 | (R−1).
- R6: `done` is high for exactly one cycle, on the same edge that clears bypass, and `busy` falls on that edge.
- R7: `start` is ignored while `busy` is high. The control words and timing of the running sequence are unaffected.
- R8: A request with any divider of 0 or above its maximum (8192 feedback, 64 reference, 8 output) is ignored. `busy` stays 0 and both control words keep their values.
- R9: Power-down (bit 24) and fast-enable (bit 27) of `ctl1` are always 0.
- R10: Clock cycles without a `ref_tick` pulse do not advance the lock wait.
- R11: A synchronous reset in the middle of a sequence returns the block at once to the R1 state. A later request then runs normally.
- R12: The extreme dividers encode to full fields. F=8192, R=64, OD=8 give `ctl0` = 0xFFF1_FFF7 and a final `ctl1` of 0x0400_003F. F=R=OD=1 give `ctl0` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| fb_div | input | FB_W+1 (14) | True feedback divider, 1..8192 |
| ref_div | input | REF_W+1 (7) | True reference divider, 1..64 |
| od_div | input | OD_W+1 (4) | True output divider, 1..8 |
| ref_tick | input | 1 | One pulse per synthesiser input-clock cycle |
| ctl0 | output | 32 | Control word 0: bandwidth, feedback and output divider fields |
| ctl1 | output | 32 | Control word 1: reset, fast, saturation, bypass, power-down and reference divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when bypass is cleared |

## Verification
Requests are run with `ref_tick` high on every cycle and then on every third cycle. This separates a lock wait that counts pulses from one that counts clocks. Small, mid-range and extreme dividers show whether each field is placed at the right offset, whether the minus-one encoding is applied, and whether the bandwidth field is derived from the encoded feedback value rather than the true one. Out-of-range requests, a `start` pulsed during a run, and a reset in the middle of a lock wait check that the sequence is entered and left only through its defined paths.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
   localparam int CW_W = 32;

   // control word 1 flag positions
   localparam int CW1_RST  = 28;
   localparam int CW1_FAST = 27;
   localparam int CW1_SAT  = 26;
   localparam int CW1_BYP  = 25;
   localparam int CW1_PWD  = 24;
   localparam int CW1_REF_LSB = 0;

   // control word 0 field positions
   localparam int CW0_BW_LSB = 20;
   localparam int CW0_FB_LSB = 4;
   localparam int CW0_OD_LSB = 0;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD1 = 3'd1,
      ST_LOAD0 = 3'd2,
      ST_HOLD  = 3'd3,
      ST_LOCK  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/pllseq_divchk.sv
module pllseq_divchk #(
   parameter int W = 6
) (
   input  logic [W:0]   true_v,
   output logic         ok,
   output logic [W-1:0] enc
);
   localparam logic [W:0] MAX_V = (W+1)'(1) << W;

   always_comb begin
      ok  = (true_v != '0) && (true_v <= MAX_V);
      enc = W'(true_v - (W+1)'(1));
   end
endmodule

// File: rtl/pllseq_encode.sv
module pllseq_encode #(
   parameter int FB_W  = 13,
   parameter int REF_W = 6,
   parameter int OD_W  = 3,
   parameter int BW_W  = 12
) (
   input  logic [FB_W:0]    fb_true,
   input  logic [REF_W:0]   ref_true,
   input  logic [OD_W:0]    od_true,
   output logic             req_ok,
   output logic [FB_W-1:0]  fb_enc,
   output logic [REF_W-1:0] ref_enc,
   output logic [OD_W-1:0]  od_enc,
   output logic [BW_W-1:0]  bw_enc
);
   logic fb_ok, ref_ok, od_ok;

   pllseq_divchk #(.W(FB_W)) u_fb (
      .true_v(fb_true), .ok(fb_ok), .enc(fb_enc));
   pllseq_divchk #(.W(REF_W)) u_ref (
      .true_v(ref_true), .ok(ref_ok), .enc(ref_enc));
   pllseq_divchk #(.W(OD_W)) u_od (
      .true_v(od_true), .ok(od_ok), .enc(od_enc));

   always_comb begin
      req_ok = fb_ok && ref_ok && od_ok;
      bw_enc = fb_enc[FB_W-1:1];
   end
endmodule

// File: rtl/pllseq_ustimer.sv
module pllseq_ustimer #(
   parameter int CYCLES_PER_US = 50,
   parameter int HOLD_US       = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int US_W = (HOLD_US > 1) ? $clog2(HOLD_US + 1) : 1;
   localparam logic [US_W-1:0] US_LAST = US_W'(HOLD_US - 1);

   logic            us_tick;
   logic [US_W-1:0] us_cnt;

   generate
      if (CYCLES_PER_US == 1) begin : g_direct
         always_comb us_tick = run;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(CYCLES_PER_US);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_US - 1);
         logic [PRE_W-1:0] pre_cnt;

         always_comb us_tick = run && (pre_cnt == PRE_LAST);

         always_ff @(posedge clk) begin
            if (rst || clear) begin
               pre_cnt <= '0;
            end else if (run) begin
               pre_cnt <= us_tick ? '0 : pre_cnt + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         us_cnt <= '0;
      end else if (us_tick) begin
         us_cnt <= us_cnt + 1'b1;
      end
   end

   always_comb expired = us_tick && (us_cnt == US_LAST);
endmodule

// File: rtl/pllseq_lockcnt.sv
module pllseq_lockcnt #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             tick,
   input  logic [CNT_W-1:0] target,
   output logic             reached
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_comb reached = tick && (cnt == target - 1'b1);
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
   import pllseq_pkg::*;
#(
   parameter int CYCLES_PER_US = 50,
   parameter int HOLD_US       = 5,
   parameter int LOCK_PERIODS  = 500,
   parameter int FB_W          = 13,
   parameter int REF_W         = 6,
   parameter int OD_W          = 3,
   parameter int BW_W          = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [FB_W:0]    fb_div,
   input  logic [REF_W:0]   ref_div,
   input  logic [OD_W:0]    od_div,
   input  logic             ref_tick,
   output logic [CW_W-1:0]  ctl0,
   output logic [CW_W-1:0]  ctl1,
   output logic             busy,
   output logic             done
);
   localparam int LOCK_MAX = LOCK_PERIODS * (1 << REF_W);
   localparam int LOCK_W   = $clog2(LOCK_MAX + 1);
   localparam logic [CW_W-1:0] CW1_RESET_VAL =
      (CW_W'(1) << CW1_RST) | (CW_W'(1) << CW1_BYP);

   // elaboration-time parameter checks
   generate
      if (BW_W != FB_W - 1) begin : g_bad_bw
         $error("BW_W must equal FB_W-1");
      end
      if (CW0_FB_LSB + FB_W > CW0_BW_LSB || CW0_BW_LSB + BW_W > CW_W) begin : g_bad_cw0
         $error("control word 0 fields overlap or overflow");
      end
      if (CW0_OD_LSB + OD_W > CW0_FB_LSB) begin : g_bad_od
         $error("output divider field overlaps feedback field");
      end
      if (CW1_REF_LSB + REF_W > CW1_PWD) begin : g_bad_ref
         $error("reference divider field overlaps flags");
      end
      if (CYCLES_PER_US < 1 || HOLD_US < 1 || LOCK_PERIODS < 1) begin : g_bad_time
         $error("timing parameters must be positive");
      end
   endgenerate

   seq_state_e state;

   logic             req_ok;
   logic [FB_W-1:0]  fb_enc,  fb_q;
   logic [REF_W-1:0] ref_enc, ref_q;
   logic [OD_W-1:0]  od_enc,  od_q;
   logic [BW_W-1:0]  bw_enc,  bw_q;
   logic [LOCK_W-1:0] lock_target;
   logic             hold_done, lock_done;
   logic [CW_W-1:0]  cw0_new, cw1_load;

   pllseq_encode #(
      .FB_W(FB_W), .REF_W(REF_W), .OD_W(OD_W), .BW_W(BW_W)
   ) u_enc (
      .fb_true (fb_div),
      .ref_true(ref_div),
      .od_true (od_div),
      .req_ok  (req_ok),
      .fb_enc  (fb_enc),
      .ref_enc (ref_enc),
      .od_enc  (od_enc),
      .bw_enc  (bw_enc)
   );

   pllseq_ustimer #(
      .CYCLES_PER_US(CYCLES_PER_US), .HOLD_US(HOLD_US)
   ) u_hold (
      .clk    (clk),
      .rst    (rst),
      .clear  (state == ST_LOAD0),
      .run    (state == ST_HOLD),
      .expired(hold_done)
   );

   pllseq_lockcnt #(.CNT_W(LOCK_W)) u_lock (
      .clk    (clk),
      .rst    (rst),
      .clear  (state != ST_LOCK),
      .tick   ((state == ST_LOCK) && ref_tick),
      .target (lock_target),
      .reached(lock_done)
   );

   // word images built from the latched request
   always_comb begin
      cw0_new = '0;
      cw0_new[CW0_BW_LSB +: BW_W] = bw_q;
      cw0_new[CW0_FB_LSB +: FB_W] = fb_q;
      cw0_new[CW0_OD_LSB +: OD_W] = od_q;

      cw1_load = '0;
      cw1_load[CW1_RST] = 1'b1;
      cw1_load[CW1_SAT] = 1'b1;
      cw1_load[CW1_BYP] = 1'b1;
      cw1_load[CW1_REF_LSB +: REF_W] = ref_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         ctl0        <= '0;
         ctl1        <= CW1_RESET_VAL;
         busy        <= 1'b0;
         done        <= 1'b0;
         fb_q        <= '0;
         ref_q       <= '0;
         od_q        <= '0;
         bw_q        <= '0;
         lock_target <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start && req_ok) begin
                  fb_q        <= fb_enc;
                  ref_q       <= ref_enc;
                  od_q        <= od_enc;
                  bw_q        <= bw_enc;
                  lock_target <= LOCK_W'(LOCK_PERIODS) * LOCK_W'(ref_div);
                  busy        <= 1'b1;
                  state       <= ST_LOAD1;
               end
            end
            ST_LOAD1: begin
               ctl1  <= cw1_load;
               state <= ST_LOAD0;
            end
            ST_LOAD0: begin
               ctl0  <= cw0_new;
               state <= ST_HOLD;
            end
            ST_HOLD: begin
               if (hold_done) begin
                  ctl1[CW1_RST] <= 1'b0;
                  state         <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (lock_done) begin
                  ctl1[CW1_BYP] <= 1'b0;
                  done          <= 1'b1;
                  busy          <= 1'b0;
                  state         <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker
   import pllseq_pkg::*;
#(
   parameter int CYCLES_PER_US = 50,
   parameter int HOLD_US       = 5,
   parameter int LOCK_PERIODS  = 500,
   parameter int FB_W          = 13,
   parameter int REF_W         = 6,
   parameter int BW_W          = 12
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            ref_tick,
   input logic [CW_W-1:0] ctl0,
   input logic [CW_W-1:0] ctl1,
   input logic            busy,
   input logic            done
);
   localparam int HOLD_CYC = CYCLES_PER_US * HOLD_US;

   int rst_run;
   int lock_ticks;

   always_ff @(posedge clk) begin
      if (rst || !(busy && ctl1[CW1_RST])) rst_run <= 0;
      else                                 rst_run <= rst_run + 1;
   end

   always_ff @(posedge clk) begin
      if (rst || !busy)
         lock_ticks <= 0;
      else if (ctl1[CW1_BYP] && !ctl1[CW1_RST] && ref_tick)
         lock_ticks <= lock_ticks + 1;
   end

   AST_BYPASS_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ctl1[CW1_BYP]);                            // R2
   AST_BW_TRACKS_FB: assert property (@(posedge clk) disable iff (rst)
      ctl0[CW0_BW_LSB +: BW_W] == ctl0[CW0_FB_LSB+1 +: FB_W-1]);           // R3
   AST_RELEASE_UNDER_BYPASS: assert property (@(posedge clk) disable iff (rst)
      $fell(ctl1[CW1_RST]) |-> ctl1[CW1_BYP]);                             // R4
   AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (rst)
      $fell(ctl1[CW1_RST]) |-> (rst_run >= HOLD_CYC));                     // R4
   AST_LOCK_LENGTH: assert property (@(posedge clk) disable iff (rst)
      $fell(ctl1[CW1_BYP]) |->
         (lock_ticks >= LOCK_PERIODS * (int'(ctl1[REF_W-1:0]) + 1)));      // R5
   AST_DONE_AT_EXIT: assert property (@(posedge clk) disable iff (rst)
      done |-> (!ctl1[CW1_BYP] && !busy && $fell(ctl1[CW1_BYP])));         // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                                     // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |=> ($stable(ctl0) && $stable(ctl1)));                         // R8
   AST_NO_PWDN_FAST: assert property (@(posedge clk) disable iff (rst)
      !ctl1[CW1_PWD] && !ctl1[CW1_FAST]);                                  // R9
   AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !done) |=> busy);                                  // R7
endmodule

bind pllseq_top pllseq_checker #(
   .CYCLES_PER_US(CYCLES_PER_US),
   .HOLD_US      (HOLD_US),
   .LOCK_PERIODS (LOCK_PERIODS),
   .FB_W         (FB_W),
   .REF_W        (REF_W),
   .BW_W         (BW_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .ref_tick(ref_tick),
   .ctl0    (ctl0),
   .ctl1    (ctl1),
   .busy    (busy),
   .done    (done)
);

// File: tb/pllseq_top_bench.sv
module pllseq_top_bench;
   localparam int CPU   = 4;
   localparam int HUS   = 5;
   localparam int LOCKP = 20;
   localparam int H     = CPU * HUS;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [13:0] fb_div = 14'd1;
   logic [6:0]  ref_div = 7'd1;
   logic [3:0]  od_div = 4'd1;
   logic        ref_tick = 1'b0;
   logic [31:0] ctl0, ctl1;
   logic        busy, done;

   int checks = 0;
   int errors = 0;
   int wd = 0;
   int tick_mode = 0;
   int tdiv = 0;

   pllseq_top #(.CYCLES_PER_US(CPU), .HOLD_US(HUS), .LOCK_PERIODS(LOCKP)) u_pllseq_top (
      .clk(clk), .rst(rst), .start(start), .fb_div(fb_div), .ref_div(ref_div),
      .od_div(od_div), .ref_tick(ref_tick), .ctl0(ctl0), .ctl1(ctl1),
      .busy(busy), .done(done));

   always #10 clk = ~clk;   // 50 MHz

   // ---------------- expected values from the requirements ----------------
   function automatic logic [31:0] w0_of(int f, int od);
      return 32'(((f - 1) >> 1) << 20) | 32'((f - 1) << 4) | 32'(od - 1);
   endfunction
   function automatic logic [31:0] w1_load(int r);  return 32'h1600_0000 | 32'(r - 1); endfunction
   function automatic logic [31:0] w1_rel(int r);   return 32'h0600_0000 | 32'(r - 1); endfunction
   function automatic logic [31:0] w1_fin(int r);   return 32'h0400_0000 | 32'(r - 1); endfunction
   function automatic bit in_range(int f, int r, int od);
      return f >= 1 && f <= 8192 && r >= 1 && r <= 64 && od >= 1 && od <= 8;
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [31:0] e_ctl0 = '0, e_ctl1 = 32'h1200_0000;
   logic        e_busy = 1'b0, e_done = 1'b0;
   bit    started = 0, m_act = 0, m_lock = 0;
   int    cyc = 0, t0 = 0, mF = 1, mR = 1, mO = 1, m_ticks = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      cyc++;
      started = 1;
      if (rst) begin
         m_act = 0; m_lock = 0;
         e_ctl0 = '0; e_ctl1 = 32'h1200_0000; e_busy = 0; e_done = 0;
         m_tag = "R11";
      end else begin
         e_done = 0;
         if (!m_act) begin
            if (start && in_range(int'(fb_div), int'(ref_div), int'(od_div))) begin
               m_act = 1; m_lock = 0; t0 = cyc;
               mF = int'(fb_div); mR = int'(ref_div); mO = int'(od_div);
               e_busy = 1; m_tag = "R2";
            end
         end else begin
            int k;
            k = cyc - t0;
            if (k == 1) e_ctl1 = w1_load(mR);
            else if (k == 2) begin e_ctl0 = w0_of(mF, mO); m_tag = "R4"; end
            else if (k == 2 + H) begin
               e_ctl1 = w1_rel(mR); m_lock = 1; m_ticks = 0; m_tag = "R5";
            end else if (m_lock && ref_tick) begin
               m_ticks++;
               if (m_ticks == LOCKP * mR) begin
                  e_ctl1 = w1_fin(mR); e_done = 1; e_busy = 0; m_act = 0; m_tag = "R6";
               end
            end
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         checks++;
         if (ctl0 !== e_ctl0) begin
            errors++; $display("FAIL R3 ctl0 actual %h expected %h", ctl0, e_ctl0);
         end else if (ctl1 !== e_ctl1) begin
            errors++; $display("FAIL %s ctl1 actual %h expected %h", m_tag, ctl1, e_ctl1);
         end else if (busy !== e_busy || done !== e_done) begin
            errors++; $display("FAIL %s busy/done actual %b%b expected %b%b",
                               m_tag, busy, done, e_busy, e_done);
         end
         if (ctl1[24] !== 1'b0 || ctl1[27] !== 1'b0) begin
            errors++; $display("FAIL R9 ctl1 actual %h expected bits 27,24 clear", ctl1);
         end
      end
   end

   // ref_tick pattern: every cycle (mode 0) or every third cycle (mode 1)
   always @(negedge clk) begin
      tdiv = (tdiv + 1) % 3;
      ref_tick = (tick_mode == 0) ? 1'b1 : (tdiv == 0);
   end

   // watchdog
   always @(negedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d cycles expected completion", wd);
         summary();
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic request(int f, int r, int od);
      @(negedge clk);
      fb_div = 14'(f); ref_div = 7'(r); od_div = 4'(od); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
      chk(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {30'b0, busy, done}, 32'h1);
      @(negedge clk);
      chk(done === 1'b0, "R6 single-cycle done", {31'b0, done}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(ctl0 === 32'h0 && ctl1 === 32'h1200_0000 && !busy && !done,
          "R1 reset state", ctl1, 32'h1200_0000);

      // R2 R3 R4 R5: mid-range request, tick every cycle
      request(100, 3, 2);
      chk(busy === 1'b1, "R2 busy after accept", {31'b0, busy}, 32'h1);
      wait_done();
      chk(ctl0 === w0_of(100, 2), "R3 ctl0 fields", ctl0, w0_of(100, 2));
      chk(ctl1 === w1_fin(3), "R5 final ctl1", ctl1, w1_fin(3));

      // R10: sparse ticks
      tick_mode = 1;
      request(50, 5, 4);
      wait_done();
      chk(ctl1 === w1_fin(5), "R10 sparse-tick final ctl1", ctl1, w1_fin(5));
      tick_mode = 0;

      // R7: start during a run is ignored
      request(200, 2, 3);
      repeat (5) @(negedge clk);
      fb_div = 14'd300; ref_div = 7'd4; od_div = 4'd5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      chk(ctl0 === w0_of(200, 3), "R7 ctl0 kept first request", ctl0, w0_of(200, 3));
      chk(ctl1 === w1_fin(2), "R7 ctl1 kept first request", ctl1, w1_fin(2));

      // R8: out-of-range requests
      begin
         logic [31:0] c0, c1;
         c0 = ctl0; c1 = ctl1;
         request(0, 1, 1);
         request(1, 65, 1);
         request(1, 1, 9);
         request(8193, 1, 1);
         repeat (2) @(negedge clk);
         chk(busy === 1'b0, "R8 busy stays low", {31'b0, busy}, 32'h0);
         chk(ctl0 === c0 && ctl1 === c1, "R8 words unchanged", ctl1, c1);
      end

      // R12: extremes
      request(8192, 64, 8);
      wait_done();
      chk(ctl0 === 32'hFFF1_FFF7, "R12 max ctl0", ctl0, 32'hFFF1_FFF7);
      chk(ctl1 === 32'h0400_003F, "R12 max ctl1", ctl1, 32'h0400_003F);
      request(1, 1, 1);
      wait_done();
      chk(ctl0 === 32'h0, "R12 min ctl0", ctl0, 32'h0);

      // R11: reset in mid sequence, then a normal run
      request(77, 6, 5);
      repeat (H + 10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(ctl0 === 32'h0 && ctl1 === 32'h1200_0000 && busy === 1'b0,
          "R11 reset mid-run", ctl1, 32'h1200_0000);
      request(77, 6, 5);
      wait_done();
      chk(ctl1 === w1_fin(6), "R11 run after reset", ctl1, w1_fin(6));

      repeat (3) @(negedge clk);
      summary();
   end
endmodule